// File: doc/BRIEF.md
# Register-Offset Word Load Address Unit

This unit accepts one word-load instruction that takes its offset from a register. It then produces everything the load needs except the memory and the register file. Three encodings share a single datapath: a 32-bit wide form, a 16-bit short form and a 32-bit narrow form. The narrow form is presented as its two halfwords concatenated, with the first halfword in the upper half. The unit decodes the register fields and puts the base and index selectors on a register-file read port. It shifts the index value and adds it to or subtracts it from the base, then selects the access address. It issues one word read over a valid/ready request channel.

When the read data returns, the unit produces three results in the same cycle: the destination register write, a base writeback when the mode asks for one, or a PC-load pulse when the destination is register 15. A separate pulse marks an encoding that belongs to a different instruction. Another pulse marks a forbidden register combination or a misaligned PC load. Neither of these cases is executed. A condition-passed input gates execution, and two status inputs tell the unit whether it sits inside a conditional block and whether it is that block's last instruction.

Top module: `ldr_reg_unit`

## Requirements
- R1: Wide form (enc_i=00, layout cond[31:28], 011 in [27:25], P[24], U[23], 0 in [22], W[21], 1 in [20], base[19:16], dest[15:12], imm5[11:7], shift type[6:5], 0 in [4], index[3:0]). The offset address is base+shifted index when U=1 and base−shifted index when U=0. The access address is the offset address when P=1 and the base value when P=0.
- R2: In the wide form, a base writeback happens when P=0 or W=1. It writes the offset address to the base register in the cycle the read data returns, on wb_we_o/wb_idx_o/wb_data_o.
- R3: other_insn_o pulses for one cycle, the cycle after acceptance, and no read request is made, in these cases: wide form with P=0 and W=1; a wide condition of 1111; any fixed wide bit that differs from its required value; a short-form opcode other than 0101100; a narrow-form upper 12 bits other than 111110000101; a narrow base of 1111; nonzero narrow bits [11:6] of the second halfword; or enc_i=11. The pulse is independent of cond_pass_i.
- R4: Wide shift types are 00 LSL, 01 LSR, 10 ASR and 11 ROR, each by imm5. An imm5 of 0 means LSR by 32 (result 0), ASR by 32 (all sign bits), or a one-bit rotate right with carry_i entering bit 31.
- R5: Short form (enc_i=01, insn_i[15:9]=0101100, index [8:6], base [5:3], dest [2:0], each a 3-bit register number) adds the unshifted index, always uses the offset address, and never writes back.
- R6: Narrow form (enc_i=10, insn_i[31:20]=111110000101, base [19:16], dest [15:12], zeros in [11:6], shift [5:4], index [3:0]) adds the index shifted left by 0–3, always uses the offset address, and never writes back.
- R7: unpred_o pulses the cycle after acceptance, with no read request, when the index register is 15, or in the wide form when writeback is on and the base is 15 or equals the destination. It is never raised together with other_insn_o.
- R8: When the destination is 15 and the access address bits [1:0] are 00, the returned word raises pc_load_o with the word on rd_data_o and rd_we_o low. Any other alignment raises unpred_o instead, and no request is made.
- R9: In the narrow form, a destination of 15 when in_cblk_i=1 and last_cblk_i=0 raises unpred_o. When last_cblk_i=1 it executes normally.
- R10: When cond_pass_i is low at acceptance, no read request, register write, writeback or PC load results.
- R11: At most one load is in flight. insn_ready_o is low from acceptance until the response cycle. mem_req_valid_o stays high with a stable address until mem_req_ready_i. The writes appear combinationally in the cycle mem_rsp_valid_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| insn_valid_i | input | 1 | Instruction offered |
| insn_ready_o | output | 1 | Unit idle, instruction accepted when valid |
| enc_i | input | 2 | Encoding: 00 wide, 01 short, 10 narrow, 11 reserved |
| insn_i | input | 32 | Instruction bits (short form in [15:0]) |
| cond_pass_i | input | 1 | Condition check passed |
| carry_i | input | 1 | Carry flag for rotate-with-carry |
| in_cblk_i | input | 1 | Instruction is inside a conditional block |
| last_cblk_i | input | 1 | Instruction is the last of that block |
| rf_base_sel_o | output | 4 | Base register read select |
| rf_index_sel_o | output | 4 | Index register read select |
| rf_base_data_i | input | DW | Base register value |
| rf_index_data_i | input | DW | Index register value |
| mem_req_valid_o | output | 1 | Word read request |
| mem_req_ready_i | input | 1 | Request taken |
| mem_req_addr_o | output | DW | Read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_data_i | input | DW | Read data |
| rd_we_o | output | 1 | Destination register write |
| rd_idx_o | output | 4 | Destination register number |
| rd_data_o | output | DW | Loaded word (register or PC) |
| pc_load_o | output | 1 | Loaded word goes to the PC |
| wb_we_o | output | 1 | Base writeback |
| wb_idx_o | output | 4 | Base register number |
| wb_data_o | output | DW | Writeback value |
| other_insn_o | output | 1 | Encoding is a different instruction |
| unpred_o | output | 1 | Unpredictable combination |

## Verification
A wrong decoded field or shift shows up as a wrong mem_req_addr_o in the cycle right after acceptance, or as wrong register selectors in the acceptance cycle itself. A corrupted latched destination, mode or writeback value stays hidden until the response cycle, where it appears on rd_idx_o, pc_load_o or the wb_* outputs. A stuck state machine shows as insn_ready_o or mem_req_valid_o holding the wrong level one cycle after a handshake. The bench therefore checks every output at each of these cycles.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int RIW = 4;
  localparam logic [RIW-1:0] PC_IDX = 4'hF;

  typedef enum logic [1:0] {ENC_WIDE = 2'b00, ENC_N16 = 2'b01, ENC_N32 = 2'b10, ENC_RSV = 2'b11} enc_e;
  typedef enum logic [1:0] {SH_LSL = 2'b00, SH_LSR = 2'b01, SH_ASR = 2'b10, SH_ROR = 2'b11} shift_e;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT} state_e;

  typedef struct packed {
    logic [RIW-1:0] base;
    logic [RIW-1:0] index;
    logic [RIW-1:0] dst;
    logic           add;
    logic           pre;
    logic           wback;
    shift_e         sh_type;
    logic [4:0]     sh_amt;
    logic           other;
    logic           unpred;
  } dec_t;
endpackage

// File: rtl/ldr_decode.sv
module ldr_decode
  import ldr_pkg::*;
(
  input  logic [1:0]  enc_i,
  input  logic [31:0] insn_i,
  input  logic        in_cblk_i,
  input  logic        last_cblk_i,
  output dec_t        dec_o
);
  dec_t d;
  logic unp;

  always_comb begin
    d         = '0;
    d.sh_type = SH_LSL;
    unp       = 1'b0;
    unique case (enc_e'(enc_i))
      ENC_WIDE: begin
        d.base    = insn_i[19:16];
        d.dst     = insn_i[15:12];
        d.index   = insn_i[3:0];
        d.sh_amt  = insn_i[11:7];
        d.sh_type = shift_e'(insn_i[6:5]);
        d.pre     = insn_i[24];
        d.add     = insn_i[23];
        d.wback   = !insn_i[24] || insn_i[21];
        d.other   = (insn_i[31:28] == 4'hF) || (insn_i[27:25] != 3'b011) || insn_i[22]
                    || !insn_i[20] || insn_i[4] || (!insn_i[24] && insn_i[21]);
        unp       = (d.index == PC_IDX) || (d.wback && (d.base == PC_IDX || d.base == d.dst));
      end
      ENC_N16: begin
        d.index = {1'b0, insn_i[8:6]};
        d.base  = {1'b0, insn_i[5:3]};
        d.dst   = {1'b0, insn_i[2:0]};
        d.add   = 1'b1;
        d.pre   = 1'b1;
        d.other = insn_i[15:9] != 7'b0101100;
      end
      ENC_N32: begin
        d.base   = insn_i[19:16];
        d.dst    = insn_i[15:12];
        d.index  = insn_i[3:0];
        d.sh_amt = {3'b000, insn_i[5:4]};
        d.add    = 1'b1;
        d.pre    = 1'b1;
        d.other  = (insn_i[31:20] != 12'hF85) || (insn_i[19:16] == PC_IDX) || (insn_i[11:6] != 6'd0);
        unp      = (d.index == PC_IDX) || (d.dst == PC_IDX && in_cblk_i && !last_cblk_i);
      end
      default: d.other = 1'b1;
    endcase
    d.unpred = unp && !d.other;
  end

  assign dec_o = d;
endmodule

// File: rtl/ldr_shift.sv
module ldr_shift
  import ldr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] val_i,
  input  shift_e        type_i,
  input  logic [4:0]    amt_i,
  input  logic          carry_i,
  output logic [DW-1:0] res_o
);
  logic [2*DW-1:0] rot;

  assign rot = {val_i, val_i} >> amt_i;

  always_comb begin
    unique case (type_i)
      SH_LSL: res_o = val_i << amt_i;
      SH_LSR: res_o = (amt_i == 5'd0) ? '0 : (val_i >> amt_i);
      SH_ASR: res_o = (amt_i == 5'd0) ? {DW{val_i[DW-1]}} : DW'($signed(val_i) >>> amt_i);
      default: res_o = (amt_i == 5'd0) ? {carry_i, val_i[DW-1:1]} : rot[DW-1:0];
    endcase
  end
endmodule

// File: rtl/ldr_agen.sv
module ldr_agen #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] base_i,
  input  logic [DW-1:0] off_i,
  input  logic          add_i,
  input  logic          pre_i,
  output logic [DW-1:0] offs_addr_o,
  output logic [DW-1:0] acc_addr_o
);
  assign offs_addr_o = add_i ? (base_i + off_i) : (base_i - off_i);
  assign acc_addr_o  = pre_i ? offs_addr_o : base_i;
endmodule

// File: rtl/ldr_reg_unit.sv
module ldr_reg_unit
  import ldr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          insn_valid_i,
  output logic          insn_ready_o,
  input  logic [1:0]    enc_i,
  input  logic [31:0]   insn_i,
  input  logic          cond_pass_i,
  input  logic          carry_i,
  input  logic          in_cblk_i,
  input  logic          last_cblk_i,
  output logic [3:0]    rf_base_sel_o,
  output logic [3:0]    rf_index_sel_o,
  input  logic [DW-1:0] rf_base_data_i,
  input  logic [DW-1:0] rf_index_data_i,
  output logic          mem_req_valid_o,
  input  logic          mem_req_ready_i,
  output logic [DW-1:0] mem_req_addr_o,
  input  logic          mem_rsp_valid_i,
  input  logic [DW-1:0] mem_rsp_data_i,
  output logic          rd_we_o,
  output logic [3:0]    rd_idx_o,
  output logic [DW-1:0] rd_data_o,
  output logic          pc_load_o,
  output logic          wb_we_o,
  output logic [3:0]    wb_idx_o,
  output logic [DW-1:0] wb_data_o,
  output logic          other_insn_o,
  output logic          unpred_o
);
  dec_t           dec;
  logic [DW-1:0]  sh_off, offs_addr, acc_addr;
  logic           accept, misalign_pc, unpred_now, go, done;
  state_e         state_q;
  logic [DW-1:0]  addr_q, wbv_q;
  logic [RIW-1:0] dst_q, base_q;
  logic           wb_q, other_q, unpred_q;

  ldr_decode u_dec (
    .enc_i(enc_i), .insn_i(insn_i), .in_cblk_i(in_cblk_i), .last_cblk_i(last_cblk_i), .dec_o(dec)
  );

  ldr_shift #(.DW(DW)) u_shift (
    .val_i(rf_index_data_i), .type_i(dec.sh_type), .amt_i(dec.sh_amt), .carry_i(carry_i), .res_o(sh_off)
  );

  ldr_agen #(.DW(DW)) u_agen (
    .base_i(rf_base_data_i), .off_i(sh_off), .add_i(dec.add), .pre_i(dec.pre),
    .offs_addr_o(offs_addr), .acc_addr_o(acc_addr)
  );

  assign rf_base_sel_o  = dec.base;
  assign rf_index_sel_o = dec.index;

  assign insn_ready_o = (state_q == ST_IDLE);
  assign accept       = insn_valid_i && insn_ready_o;
  assign misalign_pc  = !dec.other && (dec.dst == PC_IDX) && (acc_addr[1:0] != 2'b00);
  assign unpred_now   = dec.unpred || misalign_pc;
  assign go           = accept && cond_pass_i && !dec.other && !unpred_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wbv_q    <= '0;
      dst_q    <= '0;
      base_q   <= '0;
      wb_q     <= 1'b0;
      other_q  <= 1'b0;
      unpred_q <= 1'b0;
    end else begin
      other_q  <= accept && dec.other;
      unpred_q <= accept && unpred_now;
      unique case (state_q)
        ST_IDLE: if (go) begin
          state_q <= ST_REQ;
          addr_q  <= acc_addr;
          wbv_q   <= offs_addr;
          dst_q   <= dec.dst;
          base_q  <= dec.base;
          wb_q    <= dec.wback;
        end
        ST_REQ:  if (mem_req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid_o = (state_q == ST_REQ);
  assign mem_req_addr_o  = addr_q;
  assign done            = (state_q == ST_WAIT) && mem_rsp_valid_i;
  assign rd_we_o         = done && (dst_q != PC_IDX);
  assign pc_load_o       = done && (dst_q == PC_IDX);
  assign rd_idx_o        = dst_q;
  assign rd_data_o       = mem_rsp_data_i;
  assign wb_we_o         = done && wb_q;
  assign wb_idx_o        = base_q;
  assign wb_data_o       = wbv_q;
  assign other_insn_o    = other_q;
  assign unpred_o        = unpred_q;
endmodule

// File: rtl/ldr_reg_unit_chk.sv
module ldr_reg_unit_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          insn_valid_i,
  input logic          insn_ready_o,
  input logic          cond_pass_i,
  input logic          mem_req_valid_o,
  input logic          mem_req_ready_i,
  input logic [DW-1:0] mem_req_addr_o,
  input logic          mem_rsp_valid_i,
  input logic          rd_we_o,
  input logic [3:0]    rd_idx_o,
  input logic          pc_load_o,
  input logic          wb_we_o,
  input logic [3:0]    wb_idx_o,
  input logic          other_insn_o,
  input logic          unpred_o
);
  p_req_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  p_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !insn_ready_o);

  p_write_on_rsp_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_we_o || wb_we_o || pc_load_o) |-> mem_rsp_valid_i);

  p_pc_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> !rd_we_o);

  p_wb_conflict_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_we_o && rd_we_o) |-> (wb_idx_o != rd_idx_o));

  p_flag_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(other_insn_o && unpred_o));

  p_other_noreq_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (other_insn_o || unpred_o) |-> !mem_req_valid_o);

  p_cond_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(insn_valid_i && insn_ready_o && !cond_pass_i) |-> !mem_req_valid_o);
endmodule

bind ldr_reg_unit ldr_reg_unit_chk #(.DW(DW)) u_chk (.*);

// File: tb/ldr_reg_unit_tb.sv
`timescale 1ns/1ps
module ldr_reg_unit_tb;
  localparam int DW = 32;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk_i = ~clk_i;

  logic          insn_valid_i = 0, cond_pass_i = 0, carry_i = 0, in_cblk_i = 0, last_cblk_i = 0;
  logic [1:0]    enc_i = 0;
  logic [31:0]   insn_i = 0;
  logic          mem_req_ready_i = 0, mem_rsp_valid_i = 0;
  logic [DW-1:0] mem_rsp_data_i = 0;
  logic          insn_ready_o, mem_req_valid_o, rd_we_o, pc_load_o, wb_we_o, other_insn_o, unpred_o;
  logic [3:0]    rf_base_sel_o, rf_index_sel_o, rd_idx_o, wb_idx_o;
  logic [DW-1:0] rf_base_data_i, rf_index_data_i, mem_req_addr_o, rd_data_o, wb_data_o;

  logic [31:0] rf [16];
  assign rf_base_data_i  = rf[rf_base_sel_o];
  assign rf_index_data_i = rf[rf_index_sel_o];

  ldr_reg_unit #(.DW(DW)) u_dut (.*);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] wide(int cnd, int p, int u, int w, int rn, int rt, int imm5, int st, int rm);
    return {4'(cnd), 3'b011, 1'(p), 1'(u), 1'b0, 1'(w), 1'b1, 4'(rn), 4'(rt), 5'(imm5), 2'(st), 1'b0, 4'(rm)};
  endfunction
  function automatic logic [31:0] n16(int rm, int rn, int rt);
    return {16'h0, 7'b0101100, 3'(rm), 3'(rn), 3'(rt)};
  endfunction
  function automatic logic [31:0] n32(int rn, int rt, int imm2, int rm);
    return {12'hF85, 4'(rn), 4'(rt), 6'd0, 2'(imm2), 4'(rm)};
  endfunction

  // behavioural reference: returns expected outcome of one instruction
  task automatic model(input logic [1:0] enc, input logic [31:0] ins, input bit cp, ib, lb, cy,
                       output bit e_oth, output bit e_unp, output bit e_exe, output logic [31:0] e_addr,
                       output int e_dst, output int e_base, output int e_idx, output bit e_wb,
                       output logic [31:0] e_wbv);
    int stype, amt, n;
    bit p, u, wb;
    logic [31:0] v, oa;
    e_oth = 0; e_unp = 0; p = 1; u = 1; wb = 0; stype = 0; amt = 0;
    e_base = 0; e_idx = 0; e_dst = 0;
    if (enc == 2'd0) begin
      e_base = int'(ins[19:16]); e_dst = int'(ins[15:12]); e_idx = int'(ins[3:0]);
      p = ins[24]; u = ins[23]; amt = int'(ins[11:7]); stype = int'(ins[6:5]);
      wb = !p || ins[21];
      e_oth = ins[31:28] == 4'hF || ins[27:25] != 3'b011 || ins[22] || !ins[20] || ins[4] || (!p && ins[21]);
      e_unp = e_idx == 15 || (wb && (e_base == 15 || e_base == e_dst));
    end else if (enc == 2'd1) begin
      e_idx = int'(ins[8:6]); e_base = int'(ins[5:3]); e_dst = int'(ins[2:0]);
      e_oth = ins[15:9] != 7'b0101100;
    end else if (enc == 2'd2) begin
      e_base = int'(ins[19:16]); e_dst = int'(ins[15:12]); e_idx = int'(ins[3:0]); amt = int'(ins[5:4]);
      e_oth = ins[31:20] != 12'hF85 || e_base == 15 || ins[11:6] != 0;
      e_unp = e_idx == 15 || (e_dst == 15 && ib && !lb);
    end else e_oth = 1;
    v = rf[e_idx];
    n = (amt == 0) ? 32 : amt;
    case (stype)
      0: for (int i = 0; i < amt; i++) v = v << 1;
      1: for (int i = 0; i < n; i++) v = v >> 1;
      2: for (int i = 0; i < n; i++) v = {v[31], v[31:1]};
      default: if (amt == 0) v = {cy, v[31:1]};
               else for (int i = 0; i < amt; i++) v = {v[0], v[31:1]};
    endcase
    oa = u ? rf[e_base] + v : rf[e_base] - v;
    e_addr = p ? oa : rf[e_base];
    if (e_dst == 15 && e_addr[1:0] != 2'b00) e_unp = 1;
    if (e_oth) e_unp = 0;
    e_wb = wb; e_wbv = oa;
    e_exe = cp && !e_oth && !e_unp;
  endtask

  task automatic run(input string tag, input logic [1:0] enc, input logic [31:0] ins, input bit cp,
                     input bit ib, input bit lb, input bit cy, input int rdly, input int sdly);
    bit e_oth, e_unp, e_exe, e_wb;
    logic [31:0] e_addr, e_wbv, data;
    int e_dst, e_base, e_idx;
    @(negedge clk_i);
    chk(insn_ready_o === 1'b1, {tag, " R11 ready idle"}, 32'(insn_ready_o), 1);
    enc_i = enc; insn_i = ins; cond_pass_i = cp; in_cblk_i = ib; last_cblk_i = lb; carry_i = cy;
    insn_valid_i = 1;
    model(enc, ins, cp, ib, lb, cy, e_oth, e_unp, e_exe, e_addr, e_dst, e_base, e_idx, e_wb, e_wbv);
    #1;
    if (!e_oth) begin
      chk(rf_base_sel_o == 4'(e_base), {tag, " base sel"}, 32'(rf_base_sel_o), 32'(e_base));
      chk(rf_index_sel_o == 4'(e_idx), {tag, " index sel"}, 32'(rf_index_sel_o), 32'(e_idx));
    end
    @(negedge clk_i);
    insn_valid_i = 0; cond_pass_i = 0;
    #1;
    chk(other_insn_o === e_oth, {tag, " R3 other"}, 32'(other_insn_o), 32'(e_oth));
    chk(unpred_o === e_unp, {tag, " R7 unpred"}, 32'(unpred_o), 32'(e_unp));
    chk(mem_req_valid_o === e_exe, {tag, " R10 req"}, 32'(mem_req_valid_o), 32'(e_exe));
    if (!e_exe) begin
      chk(insn_ready_o === 1'b1 && !rd_we_o && !wb_we_o && !pc_load_o, {tag, " R10 idle"},
          32'(insn_ready_o), 1);
      return;
    end
    chk(mem_req_addr_o === e_addr, {tag, " R1 addr"}, mem_req_addr_o, e_addr);
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk_i); #1;
      chk(mem_req_valid_o && mem_req_addr_o === e_addr && !insn_ready_o, {tag, " R11 hold"},
          mem_req_addr_o, e_addr);
    end
    mem_req_ready_i = 1;
    @(negedge clk_i);
    mem_req_ready_i = 0;
    #1;
    chk(!mem_req_valid_o && !insn_ready_o, {tag, " R11 one req"}, 32'(mem_req_valid_o), 0);
    for (int i = 0; i < sdly; i++) begin
      @(negedge clk_i); #1;
      chk(!rd_we_o && !wb_we_o && !pc_load_o, {tag, " R11 no early write"}, 32'(rd_we_o), 0);
    end
    data = 32'hA5C3_0000 ^ e_addr;
    mem_rsp_valid_i = 1; mem_rsp_data_i = data;
    #1;
    chk(rd_we_o === (e_dst != 15), {tag, " R8 rd_we"}, 32'(rd_we_o), 32'(e_dst != 15));
    chk(pc_load_o === (e_dst == 15), {tag, " R8 pc_load"}, 32'(pc_load_o), 32'(e_dst == 15));
    chk(rd_data_o === data, {tag, " data"}, rd_data_o, data);
    if (e_dst != 15) chk(rd_idx_o == 4'(e_dst), {tag, " rd_idx"}, 32'(rd_idx_o), 32'(e_dst));
    chk(wb_we_o === e_wb, {tag, " R2 wb_we"}, 32'(wb_we_o), 32'(e_wb));
    if (e_wb) begin
      chk(wb_idx_o == 4'(e_base), {tag, " R2 wb_idx"}, 32'(wb_idx_o), 32'(e_base));
      chk(wb_data_o === e_wbv, {tag, " R2 wb_data"}, wb_data_o, e_wbv);
    end
    @(negedge clk_i);
    mem_rsp_valid_i = 0;
    #1;
    chk(insn_ready_o && !rd_we_o && !wb_we_o && !pc_load_o, {tag, " R11 back idle"}, 32'(insn_ready_o), 1);
  endtask

  initial begin
    #(8 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h0001_0000 * i + 32'h100;
    rf[3] = 32'h8000_0013; rf[5] = 32'h0000_0004; rf[9] = 32'h0000_0002; rf[15] = 32'h0000_2000;
    repeat (2) @(negedge clk_i);
    #1;
    chk(insn_ready_o && !mem_req_valid_o && !rd_we_o && !wb_we_o && !pc_load_o && !other_insn_o && !unpred_o,
        "reset idle", 32'(insn_ready_o), 1);
    rst_ni = 1;

    // R1 modes
    run("R1 offset add",   2'd0, wide(14, 1, 1, 0, 1, 2, 0, 0, 5), 1, 0, 0, 0, 0, 0);
    run("R1 offset sub",   2'd0, wide(14, 1, 0, 0, 1, 2, 0, 0, 5), 1, 0, 0, 0, 2, 1);
    // R2 writeback
    run("R2 pre wb",       2'd0, wide(0, 1, 1, 1, 1, 2, 0, 0, 5), 1, 0, 0, 0, 1, 0);
    run("R2 post",         2'd0, wide(0, 0, 0, 0, 4, 6, 0, 0, 5), 1, 0, 0, 0, 0, 3);
    // R4 shifts
    run("R4 lsl2",         2'd0, wide(14, 1, 1, 0, 1, 2, 2, 0, 3), 1, 0, 0, 0, 0, 0);
    run("R4 lsr32",        2'd0, wide(14, 1, 1, 0, 1, 2, 0, 1, 3), 1, 0, 0, 0, 0, 0);
    run("R4 lsr4",         2'd0, wide(14, 1, 1, 0, 1, 2, 4, 1, 3), 1, 0, 0, 0, 1, 1);
    run("R4 asr32",        2'd0, wide(14, 1, 1, 0, 1, 2, 0, 2, 3), 1, 0, 0, 0, 0, 0);
    run("R4 asr3",         2'd0, wide(14, 1, 0, 0, 1, 2, 3, 2, 3), 1, 0, 0, 0, 0, 0);
    run("R4 ror8",         2'd0, wide(14, 1, 1, 0, 1, 2, 8, 3, 3), 1, 0, 0, 0, 0, 0);
    run("R4 rrx",          2'd0, wide(14, 1, 1, 0, 1, 2, 0, 3, 3), 1, 0, 0, 1, 0, 0);
    // R3 other instruction
    run("R3 p0w1",         2'd0, wide(14, 0, 1, 1, 1, 2, 0, 0, 5), 1, 0, 0, 0, 0, 0);
    run("R3 cond1111",     2'd0, wide(15, 1, 1, 0, 1, 2, 0, 0, 5), 1, 0, 0, 0, 0, 0);
    run("R3 bit4",         2'd0, wide(14, 1, 1, 0, 1, 2, 0, 0, 5) | 32'h10, 1, 0, 0, 0, 0, 0);
    run("R3 enc11",        2'd3, wide(14, 1, 1, 0, 1, 2, 0, 0, 5), 1, 0, 0, 0, 0, 0);
    run("R3 cp0 other",    2'd0, wide(14, 0, 1, 1, 1, 2, 0, 0, 5), 0, 0, 0, 0, 0, 0);
    // R5 short form
    run("R5 n16",          2'd1, n16(5, 1, 7), 1, 0, 0, 0, 1, 1);
    run("R5 n16 bad op",   2'd1, n16(5, 1, 7) ^ 32'h0200, 1, 0, 0, 0, 0, 0);
    // R6 narrow form
    run("R6 n32 lsl3",     2'd2, n32(1, 4, 3, 3), 1, 0, 0, 0, 0, 2);
    run("R6 n32 lsl1",     2'd2, n32(6, 4, 1, 5), 1, 0, 0, 0, 1, 0);
    run("R6 n32 rn15",     2'd2, n32(15, 4, 1, 5), 1, 0, 0, 0, 0, 0);
    run("R6 n32 zeros",    2'd2, n32(1, 4, 1, 5) | 32'h0040, 1, 0, 0, 0, 0, 0);
    // R7 unpredictable
    run("R7 rm15",         2'd0, wide(14, 1, 1, 0, 1, 2, 0, 0, 15), 1, 0, 0, 0, 0, 0);
    run("R7 wb rn=rt",     2'd0, wide(14, 1, 1, 1, 2, 2, 0, 0, 5), 1, 0, 0, 0, 0, 0);
    run("R7 wb rn15",      2'd0, wide(14, 0, 1, 0, 15, 2, 0, 0, 5), 1, 0, 0, 0, 0, 0);
    run("R7 nowb rn=rt",   2'd0, wide(14, 1, 1, 0, 2, 2, 0, 0, 5), 1, 0, 0, 0, 0, 0);
    run("R7 n32 rm15",     2'd2, n32(1, 4, 0, 15), 1, 0, 0, 0, 0, 0);
    // R8 PC load
    run("R8 pc aligned",   2'd0, wide(14, 1, 1, 0, 1, 15, 0, 0, 5), 1, 0, 0, 0, 0, 1);
    run("R8 pc misalign",  2'd0, wide(14, 1, 1, 0, 9, 15, 0, 0, 5), 1, 0, 0, 0, 0, 0);
    // R9 conditional block
    run("R9 inblk notlast", 2'd2, n32(1, 15, 0, 5), 1, 1, 0, 0, 0, 0);
    run("R9 inblk last",    2'd2, n32(1, 15, 0, 5), 1, 1, 1, 0, 0, 0);
    // R10 condition gate
    run("R10 cp0",         2'd0, wide(14, 1, 1, 1, 1, 2, 0, 0, 5), 0, 0, 0, 0, 0, 0);
    run("R10 cp0 n16",     2'd1, n16(5, 1, 7), 0, 0, 0, 0, 0, 0);
    // R11 long waits
    run("R11 long wait",   2'd0, wide(14, 0, 1, 0, 3, 8, 1, 0, 5), 1, 0, 0, 0, 5, 4);

    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule